// File: doc/BRIEF.md
# Read-to-Accept Priority Interrupt Controller

This block collects a set of level-sensitive interrupt request lines, each tagged with a programmable 4-bit priority, and presents a single interrupt line to a processor. The processor talks to it over a small synchronous register bus: an address, a read strobe, a write strobe, a byte of write data and a 32-bit read-data return. The read data is combinational and is valid in the cycle the read strobe is high. Any side effect of that read takes hold at the next rising clock edge.

Acknowledging an interrupt takes one bus read of the accept register. In the cycle of that read the block picks the best eligible request and returns its vector. At the following edge it files the running level in a shadow register, raises the running level to the winner's priority and keeps a copy of the vector. A returned value of zero means nothing was accepted. When the handler finishes, software reads the shadow level and writes it back into the running-level register, which re-opens lower priorities.

The bus carries at most one access per cycle. If both strobes are high together, the read is serviced and the write is dropped. There is no back-pressure on this interface, because every access completes in the cycle it is presented.

Top module: `prio_accept_intc`

## Requirements
- R1: After reset the running level, the shadow level, the stored vector and every priority register read 0, and `irq` is low.
- R2: The priority of request i is read and written at address 0x100+i. Only the low 4 bits of the written byte are kept, and a read returns them zero-extended.
- R3: A request is eligible when its line is high and its priority is strictly greater than the running level. A priority of 0 is never eligible. `irq` is high in exactly the cycles in which some request is eligible.
- R4: An accept read selects the eligible request with the highest priority. On a tie, the lowest index wins. After the accept, the running level equals the winner's priority.
- R5: Request index n is encoded as the vector (n + 16) * 32. Bits 4:0 of a vector are always 0, and the top request of 16 encodes as 0x3E0.
- R6: A read of address 0x18 that finds an eligible request returns its vector in the same cycle. At the next edge, the old running level moves to the shadow register (address 0x34), the running level takes the winner's priority, and the vector is stored for reads at address 0x20.
- R7: An accept read that finds no eligible request returns 0 and leaves the running level, the shadow level and the stored vector unchanged.
- R8: A write to address 0x30 loads the low 4 bits of the byte into the running level at the next edge, and `irq` is re-evaluated against the new level from that edge on.
- R9: Reads of addresses 0x20, 0x30 and 0x34 have no side effects.
- R10: `rdata` is 0 whenever `rd_en` is low and for reads of unmapped addresses. Writes to unmapped or read-only addresses (including 0x34) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_SRC | Level-sensitive request lines |
| addr | input | 12 | Register byte address |
| rd_en | input | 1 | Read strobe; accept side effects apply at the next edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 32 | Combinational read data |
| irq | output | 1 | High while an eligible request exists |

## Verification
Several properties are checked on every cycle:
- a successful accept copies the old level to the shadow register, strictly raises the running level and stores the returned vector;
- an empty accept leaves all three registers stable;
- vectors always have the right format;
- a level write lands on the next edge;
- the bus returns 0 when no read is in progress.

Other behaviour is shown only by the bench's scenarios, where a reference model is compared against the block:
- that the winner is actually the best candidate, including lowest-index tie-breaking;
- that level-zero requests never raise `irq`;
- that restoring the shadow level re-opens suppressed requests;
- that priority writes keep only their low nibble.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W    = 12;
  localparam int RDATA_W   = 32;
  localparam int WDATA_W   = 8;
  localparam int VEC_BIAS  = 16;
  localparam int VEC_SHIFT = 5;

  localparam logic [ADDR_W-1:0] ADDR_ACCEPT    = 12'h018;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR    = 12'h020;
  localparam logic [ADDR_W-1:0] ADDR_CURLVL    = 12'h030;
  localparam logic [ADDR_W-1:0] ADDR_PRVLVL    = 12'h034;
  localparam logic [ADDR_W-1:0] ADDR_PRIO_BASE = 12'h100;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACCEPT,
    SEL_VECTOR,
    SEL_CURLVL,
    SEL_PRVLVL,
    SEL_PRIO
  } reg_sel_e;
endpackage

// File: rtl/intc_prio_bank.sv
module intc_prio_bank #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [PRIO_W-1:0]               wr_data,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q
);
  // One independent priority register per request line.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   prio_q[g] <= '0;
      else if (hit) prio_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]              req,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input  logic [PRIO_W-1:0]               cur_lvl,
  output logic                            any_elig,
  output logic [IDX_W-1:0]                win_idx,
  output logic [PRIO_W-1:0]               win_prio
);
  logic [NUM_SRC-1:0] elig;

  // A request qualifies only above the running level; level 0 never does.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = req[g] && (prio[g] > cur_lvl);
  end

  assign any_elig = |elig;

  // Ascending scan with strict compare keeps the lowest index on ties.
  always_comb begin
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (prio[i] > win_prio)) begin
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/intc_level_ctrl.sv
module intc_level_ctrl #(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_fire,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic [VEC_W-1:0]  win_vec,
  input  logic              lvl_wr,
  input  logic [PRIO_W-1:0] lvl_wdata,
  output logic [PRIO_W-1:0] cur_lvl,
  output logic [PRIO_W-1:0] prev_lvl,
  output logic [VEC_W-1:0]  vec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl  <= '0;
      prev_lvl <= '0;
      vec_q    <= '0;
    end else if (accept_fire) begin
      prev_lvl <= cur_lvl;
      cur_lvl  <= win_prio;
      vec_q    <= win_vec;
    end else if (lvl_wr) begin
      cur_lvl  <= lvl_wdata;
    end
  end
endmodule

// File: rtl/prio_accept_intc.sv
module prio_accept_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   req,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [WDATA_W-1:0]   wdata,
  output logic [RDATA_W-1:0]   rdata,
  output logic                 irq
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int VEC_W = $clog2(NUM_SRC + VEC_BIAS) + VEC_SHIFT;

  reg_sel_e                        sel;
  logic [IDX_W-1:0]                prio_idx;
  logic [ADDR_W-1:0]               prio_off;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic                            any_elig;
  logic [IDX_W-1:0]                win_idx;
  logic [PRIO_W-1:0]               win_prio;
  logic [VEC_W-1:0]                win_vec;
  logic [PRIO_W-1:0]               cur_lvl;
  logic [PRIO_W-1:0]               prev_lvl;
  logic [VEC_W-1:0]                vec_q;
  logic                            wr_ok;
  logic                            accept_fire;

  // Address decode
  assign prio_off = addr - ADDR_PRIO_BASE;
  assign prio_idx = prio_off[IDX_W-1:0];

  always_comb begin
    if (addr == ADDR_ACCEPT)      sel = SEL_ACCEPT;
    else if (addr == ADDR_VECTOR) sel = SEL_VECTOR;
    else if (addr == ADDR_CURLVL) sel = SEL_CURLVL;
    else if (addr == ADDR_PRVLVL) sel = SEL_PRVLVL;
    else if ((addr >= ADDR_PRIO_BASE) &&
             (prio_off < ADDR_W'(NUM_SRC))) sel = SEL_PRIO;
    else                          sel = SEL_NONE;
  end

  // A read in the same cycle wins over a write.
  assign wr_ok       = wr_en && !rd_en;
  assign accept_fire = rd_en && (sel == SEL_ACCEPT) && any_elig;

  intc_prio_bank #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ok && (sel == SEL_PRIO)),
    .wr_idx  (prio_idx),
    .wr_data (wdata[PRIO_W-1:0]),
    .prio_q  (prio_q)
  );

  intc_arbiter #(
    .NUM_SRC  (NUM_SRC),
    .PRIO_W   (PRIO_W),
    .IDX_W    (IDX_W)
  ) u_arb (
    .req      (req),
    .prio     (prio_q),
    .cur_lvl  (cur_lvl),
    .any_elig (any_elig),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  // Vector encoding: (index + bias) shifted into place.
  assign win_vec = VEC_W'((VEC_W'(win_idx) + VEC_W'(VEC_BIAS)) << VEC_SHIFT);

  intc_level_ctrl #(
    .PRIO_W      (PRIO_W),
    .VEC_W       (VEC_W)
  ) u_lvl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_fire (accept_fire),
    .win_prio    (win_prio),
    .win_vec     (win_vec),
    .lvl_wr      (wr_ok && (sel == SEL_CURLVL)),
    .lvl_wdata   (wdata[PRIO_W-1:0]),
    .cur_lvl     (cur_lvl),
    .prev_lvl    (prev_lvl),
    .vec_q       (vec_q)
  );

  // Read-data return mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_ACCEPT: rdata = any_elig ? RDATA_W'(win_vec) : '0;
        SEL_VECTOR: rdata = RDATA_W'(vec_q);
        SEL_CURLVL: rdata = RDATA_W'(cur_lvl);
        SEL_PRVLVL: rdata = RDATA_W'(prev_lvl);
        SEL_PRIO:   rdata = RDATA_W'(prio_q[prio_idx]);
        default:    rdata = '0;
      endcase
    end
  end

  assign irq = any_elig;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                rd_en,
  input logic                wr_en,
  input logic [WDATA_W-1:0]  wdata,
  input logic [RDATA_W-1:0]  rdata,
  input logic                irq,
  input logic [PRIO_W-1:0]   cur_lvl,
  input logic [PRIO_W-1:0]   prev_lvl,
  input logic [VEC_W-1:0]    vec_q
);
  logic acc_rd;
  logic acc_hit;
  logic lvl_wr;

  assign acc_rd  = rd_en && (addr == ADDR_ACCEPT);
  assign acc_hit = acc_rd && (rdata != '0);
  assign lvl_wr  = wr_en && !rd_en && (addr == ADDR_CURLVL);

  assert_shadow_saved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> prev_lvl == $past(cur_lvl));

  assert_level_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> cur_lvl > $past(cur_lvl));

  assert_vector_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> RDATA_W'(vec_q) == $past(rdata));

  assert_empty_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && rdata == '0) |=> ($stable(cur_lvl) && $stable(prev_lvl) && $stable(vec_q)));

  assert_no_irq_no_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !irq) |-> rdata == '0);

  assert_vector_format_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (rdata[VEC_SHIFT-1:0] == '0 && rdata[RDATA_W-1:VEC_SHIFT] >= VEC_BIAS));

  assert_level_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> cur_lvl == $past(wdata[PRIO_W-1:0]));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

bind prio_accept_intc intc_checker #(
  .PRIO_W (PRIO_W),
  .VEC_W  (VEC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .cur_lvl  (cur_lvl),
  .prev_lvl (prev_lvl),
  .vec_q    (vec_q)
);

// File: tb/tb_prio_accept_intc.sv
module tb_prio_accept_intc;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [11:0] addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int applied = 0;
  int fails   = 0;
  bit done    = 0;

  // Reference model state
  int prio_m [N];
  int cur_m, prev_m, vec_m;

  always #4 clk = ~clk;

  prio_accept_intc #(.NUM_SRC(N), .PRIO_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input string what, input longint got, input longint exp);
    applied++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Winner: find the top eligible priority, then the first index holding it.
  function automatic int model_winner();
    int best = 0;
    for (int i = 0; i < N; i++)
      if (req[i] && prio_m[i] > cur_m && prio_m[i] > best) best = prio_m[i];
    if (best == 0) return -1;
    for (int i = 0; i < N; i++)
      if (req[i] && prio_m[i] == best) return i;
    return -1;
  endfunction

  task automatic step(input bit rd, input bit wr, input int a, input int d,
                      input logic [N-1:0] r, input string tag);
    int w;
    longint exp_rd;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = 12'(a); wdata = 8'(d); req = r;
    #1;
    w = model_winner();
    exp_rd = 0;
    if (rd) begin
      if (a == 'h18)      exp_rd = (w < 0) ? 0 : (w + 16) * 32;
      else if (a == 'h20) exp_rd = vec_m;
      else if (a == 'h30) exp_rd = cur_m;
      else if (a == 'h34) exp_rd = prev_m;
      else if (a >= 'h100 && a < 'h100 + N) exp_rd = prio_m[a - 'h100];
    end
    check(tag, "irq", irq, w >= 0);
    check(tag, "rdata", rdata, exp_rd);
    // Model state update for the coming edge
    if (rd) begin
      if (a == 'h18 && w >= 0) begin
        prev_m = cur_m; cur_m = prio_m[w]; vec_m = (w + 16) * 32;
      end
    end else if (wr) begin
      if (a == 'h30) cur_m = d & 15;
      else if (a >= 'h100 && a < 'h100 + N) prio_m[a - 'h100] = d & 15;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    cur_m = 0; prev_m = 0; vec_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    step(1, 0, 'h30, 0, '0, "R1");
    step(1, 0, 'h34, 0, '0, "R1");
    step(1, 0, 'h20, 0, '0, "R1");
    step(1, 0, 'h105, 0, '1, "R1");

    // R2: priority writes keep the low nibble
    step(0, 1, 'h103, 'hA7, '0, "R2");
    step(1, 0, 'h103, 0, '0, "R2");
    step(0, 1, 'h103, 0, '0, "R2");

    // R3: level-0 requests never raise irq
    step(0, 0, 0, 0, '1, "R3");

    // R4: highest priority, tie to lowest index
    step(0, 1, 'h102, 5, '0, "R4");
    step(0, 1, 'h107, 9, '0, "R4");
    step(0, 1, 'h109, 9, '0, "R4");
    step(0, 1, 'h10C, 3, '0, "R4");
    step(1, 0, 'h18, 0, 16'h1284, "R4");   // index 7 -> 0x2E0
    step(1, 0, 'h30, 0, 16'h1284, "R4");

    // R6: shadow and vector registers after the accept; R9: no side effects
    step(1, 0, 'h34, 0, 16'h1284, "R6");
    step(1, 0, 'h20, 0, 16'h1284, "R9");

    // R7: nothing above level 9
    step(1, 0, 'h18, 0, 16'h1284, "R7");
    step(1, 0, 'h30, 0, 16'h1284, "R7");
    step(1, 0, 'h20, 0, 16'h1284, "R7");

    // R8: restore the shadow level, irq comes back
    step(0, 1, 'h30, 0, 16'h1284, "R8");
    step(0, 0, 0, 0, 16'h1284, "R8");
    step(0, 1, 'h30, 'hF4, 16'h0004, "R8");
    step(1, 0, 'h18, 0, 16'h0004, "R8");   // index 2, prio 5 > 4

    // R5: top index encodes as 0x3E0
    step(0, 1, 'h10F, 15, 16'h8004, "R5");
    step(1, 0, 'h18, 0, 16'h8004, "R5");
    step(1, 0, 'h34, 0, 16'h8004, "R5");

    // R10: idle bus, unmapped read, write to read-only shadow
    step(0, 0, 'h18, 0, 16'h8004, "R10");
    step(1, 0, 'h44, 0, 16'h8004, "R10");
    step(0, 1, 'h34, 'h0C, 16'h8004, "R10");
    step(1, 0, 'h34, 0, 16'h8004, "R10");
    step(0, 1, 'h30, 0, 16'h8004, "R10");

    // Mixed random traffic compared against the model every cycle
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 9);
      int a;
      bit rd = $urandom_range(0, 1);
      case (sel)
        0, 1, 2: a = 'h18;
        3: a = 'h20;
        4, 5: a = 'h30;
        6: a = 'h34;
        7, 8: a = 'h100 + $urandom_range(0, N - 1);
        default: a = 'h44;
      endcase
      step(rd, !rd, a, $urandom_range(0, 255), N'($urandom), "R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule